// File: doc/BRIEF.md
# Multi-Context Register with Set Swap

This block is a clocked register that keeps several independent contexts of equal width. One context is live: it sits in ordinary flip-flops, drives the data output and takes writes from the data input. The remaining contexts rest in a backing array next to the register and stay untouched until they are called back.

A caller requests a context change by raising the swap request together with the index of the wanted context. The block then runs a two-phase sequence on consecutive clock edges. First it parks the live context in the backing array. Then it copies the requested context from the array into the flip-flops. While the sequence runs, the busy output is high and normal register operation is suspended.

The context count and the context width are parameters, and a count of 64 is a legal setting.

Top module: `ctx_swap_reg`

## Requirements
- R1: After reset, busy is 0, the active index is 0, the data output is 0, and every context later read back through a swap reads 0.
- R2: When busy is 0 and the write enable is 1 at a clock edge, the data output equals the sampled data input from the next cycle on.
- R3: A swap request whose index differs from the active index is accepted when busy is 0. Busy is then high for exactly two cycles, starting in the cycle after the accepting edge.
- R4: While busy is high, the write enable has no effect, and the data output keeps the value it had when the swap was accepted.
- R5: The edge that ends busy is the same edge at which the data output takes the stored content of the requested context and the active index becomes the requested index. Before that edge, the active index keeps its old value.
- R6: A context that has been swapped out returns, when it is swapped back in, with exactly the value it held when it was swapped out.
- R7: A swap request whose index equals the active index does nothing: busy stays 0, the active index is unchanged, and a write in the same cycle still takes effect.
- R8: A swap request made while busy is high is dropped. It is not queued and does not extend the busy period.
- R9: If a write and an accepted swap request arrive in the same cycle, the write is applied first. The written value is what gets parked for the old context.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the live context |
| din | input | WIDTH | Write data for the live context |
| sw_req | input | 1 | Swap request strobe |
| sw_idx | input | IDX_W | Index of the requested context |
| dout | output | WIDTH | Content of the live context |
| active_idx | output | IDX_W | Index of the live context |
| busy | output | 1 | High while a swap is in progress |

## Verification
Two functions can fall in the same cycle: a live write and an accepted swap request. The bench drives both on a single edge and then brings the old context back through a second swap. The value read back must be the one just written, not the value held before that write. The bench also checks the lookalike case, where the index equals the active one. There, only the write may take effect and busy must stay low.

// File: rtl/cxr_pkg.sv
package cxr_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SAVE = 2'd1,
        PH_LOAD = 2'd2
    } phase_e;

endpackage

// File: rtl/cxr_ctrl.sv
module cxr_ctrl
    import cxr_pkg::*;
#(
    parameter int SETS  = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_req,
    input  logic [IDX_W-1:0] sw_idx,
    output logic             busy,
    output logic             save_en,
    output logic             load_en,
    output logic [IDX_W-1:0] active_idx,
    output logic [IDX_W-1:0] target_idx
);

    typedef struct packed {
        phase_e           phase;
        logic [IDX_W-1:0] active;
        logic [IDX_W-1:0] target;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    // Sequencer: idle -> park live context -> fetch requested context -> idle
    always_comb begin
        ctl_d   = ctl_q;
        save_en = 1'b0;
        load_en = 1'b0;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (sw_req && (sw_idx != ctl_q.active)) begin
                    ctl_d.target = sw_idx;
                    ctl_d.phase  = PH_SAVE;
                end
            end
            PH_SAVE: begin
                save_en     = 1'b1;
                ctl_d.phase = PH_LOAD;
            end
            PH_LOAD: begin
                load_en      = 1'b1;
                ctl_d.active = ctl_q.target;
                ctl_d.phase  = PH_IDLE;
            end
            default: begin
                ctl_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{phase: PH_IDLE, active: '0, target: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy       = (ctl_q.phase != PH_IDLE);
    assign active_idx = ctl_q.active;
    assign target_idx = ctl_q.target;

endmodule

// File: rtl/cxr_bank.sv
module cxr_bank #(
    parameter int WIDTH = 32,
    parameter int SETS  = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] row_q [SETS];

    // One storage row per context, each with its own write decode
    for (genvar g = 0; g < SETS; g++) begin : g_row
        logic [WIDTH-1:0] row_d;

        always_comb begin
            row_d = row_q[g];
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                row_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                row_q[g] <= '0;
            end else begin
                row_q[g] <= row_d;
            end
        end
    end

    assign rd_data = row_q[rd_idx];

endmodule

// File: rtl/cxr_live.sv
module cxr_live #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_data,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] live_d, live_q;

    // A restore from the backing array has priority over a user write
    always_comb begin
        live_d = live_q;
        if (load_en) begin
            live_d = load_data;
        end else if (wr_en) begin
            live_d = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '0;
        end else begin
            live_q <= live_d;
        end
    end

    assign q = live_q;

endmodule

// File: rtl/ctx_swap_reg.sv
module ctx_swap_reg #(
    parameter  int WIDTH = 32,
    parameter  int SETS  = 8,
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] din,
    input  logic             sw_req,
    input  logic [IDX_W-1:0] sw_idx,
    output logic [WIDTH-1:0] dout,
    output logic [IDX_W-1:0] active_idx,
    output logic             busy
);

    logic             save_en;
    logic             load_en;
    logic [IDX_W-1:0] target_idx;
    logic [WIDTH-1:0] bank_rd;
    logic [WIDTH-1:0] live_q;
    logic             user_wr;

    cxr_ctrl #(
        .SETS  (SETS),
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_req     (sw_req),
        .sw_idx     (sw_idx),
        .busy       (busy),
        .save_en    (save_en),
        .load_en    (load_en),
        .active_idx (active_idx),
        .target_idx (target_idx)
    );

    // Writes only land while no swap is running
    assign user_wr = wr_en & ~busy;

    cxr_live #(
        .WIDTH (WIDTH)
    ) u_live (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (user_wr),
        .wr_data   (din),
        .load_en   (load_en),
        .load_data (bank_rd),
        .q         (live_q)
    );

    cxr_bank #(
        .WIDTH (WIDTH),
        .SETS  (SETS),
        .IDX_W (IDX_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (save_en),
        .wr_idx  (active_idx),
        .wr_data (live_q),
        .rd_idx  (target_idx),
        .rd_data (bank_rd)
    );

    assign dout = live_q;

endmodule

// File: rtl/cxr_checker.sv
module cxr_checker #(
    parameter  int WIDTH = 32,
    parameter  int SETS  = 8,
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [WIDTH-1:0] din,
    input logic             sw_req,
    input logic [IDX_W-1:0] sw_idx,
    input logic [WIDTH-1:0] dout,
    input logic [IDX_W-1:0] active_idx,
    input logic             busy
);

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en) |=> (dout == $past(din)));

    a_r3_busy_second_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);

    // also covers R8: a request during the swap cannot stretch it
    a_r3_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |=> !busy);

    a_r4_dout_held: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> $stable(dout));

    a_r5_idx_steady: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(active_idx));

    a_r5_idx_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (active_idx != $past(active_idx)));

    a_r7_same_idx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sw_req && (sw_idx == active_idx)) |=> !busy);

endmodule

bind ctx_swap_reg cxr_checker #(
    .WIDTH (WIDTH),
    .SETS  (SETS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .din        (din),
    .sw_req     (sw_req),
    .sw_idx     (sw_idx),
    .dout       (dout),
    .active_idx (active_idx),
    .busy       (busy)
);

// File: tb/sim_ctx_swap_reg.sv
`timescale 1ns/1ps
module sim_ctx_swap_reg;

    localparam int W  = 16;
    localparam int N  = 8;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [W-1:0]  din = '0;
    logic          sw_req = 1'b0;
    logic [IW-1:0] sw_idx = '0;
    logic [W-1:0]  dout;
    logic [IW-1:0] active_idx;
    logic          busy;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    string mtag = "R1";

    always #2.5 clk = ~clk;

    ctx_swap_reg #(.WIDTH(W), .SETS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .din(din),
        .sw_req(sw_req), .sw_idx(sw_idx),
        .dout(dout), .active_idx(active_idx), .busy(busy)
    );

    // Behavioural reference model
    int         m_phase;
    int         m_act;
    int         m_tgt;
    logic [W-1:0] m_live;
    logic [W-1:0] m_store [N];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_act = 0; m_tgt = 0; m_live = '0;
            for (int k = 0; k < N; k++) m_store[k] = '0;
        end else begin
            case (m_phase)
                0: begin
                    if (wr_en) m_live = din;
                    if (sw_req && int'(sw_idx) != m_act) begin
                        m_tgt = int'(sw_idx);
                        m_phase = 1;
                    end
                end
                1: begin
                    m_store[m_act] = m_live;
                    m_phase = 2;
                end
                default: begin
                    m_live = m_store[m_tgt];
                    m_act = m_tgt;
                    m_phase = 0;
                end
            endcase
        end
    end

    task automatic chk(input string tag, input string what, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(mtag, "model dout", dout, m_live);
            chk(mtag, "model active_idx", active_idx, m_act);
            chk(mtag, "model busy", busy, (m_phase != 0));
        end
    end

    task automatic cyc(input logic w, input logic [W-1:0] d, input logic r, input logic [IW-1:0] i);
        @(negedge clk);
        wr_en = w; din = d; sw_req = r; sw_idx = i;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, '0, 1'b0, '0);
    endtask

    task automatic goto(input logic [IW-1:0] i);
        cyc(1'b0, '0, 1'b1, i);
        idle(3);
    endtask

    function automatic logic [W-1:0] pat(input int k);
        return W'(16'h1000 + k * 16'h0111);
    endfunction

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog R3 actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        mtag = "R1";
        chk("R1", "busy after reset", busy, 0);
        chk("R1", "active_idx after reset", active_idx, 0);
        chk("R1", "dout after reset", dout, 0);

        // R1 every context is zero; R2 writes land
        for (int k = 0; k < N; k++) begin
            mtag = "R1";
            goto(IW'(k));
            chk("R1", "fresh context reads zero", dout, 0);
            mtag = "R2";
            cyc(1'b1, pat(k), 1'b0, '0);
            idle(1);
            chk("R2", "written value visible", dout, pat(k));
        end

        // R6 contexts come back intact; R5 index follows
        mtag = "R6";
        for (int k = N - 1; k >= 0; k--) begin
            goto(IW'(k));
            chk("R6", "restored content", dout, pat(k));
            chk("R5", "active index after swap", active_idx, k);
        end

        // R3 busy length and R5 update edge, from context 0 to 5
        mtag = "R3";
        cyc(1'b0, '0, 1'b1, 3'd5);
        idle(1);
        chk("R3", "busy first swap cycle", busy, 1);
        idle(1);
        chk("R3", "busy second swap cycle", busy, 1);
        chk("R5", "index still old in last busy cycle", active_idx, 0);
        chk("R5", "dout still old in last busy cycle", dout, pat(0));
        idle(1);
        chk("R3", "busy released", busy, 0);
        chk("R5", "index updated with data", active_idx, 5);
        chk("R5", "data restored with index", dout, pat(5));

        // R4 write during swap ignored, dout held
        mtag = "R4";
        cyc(1'b0, '0, 1'b1, 3'd2);
        cyc(1'b1, 16'hDEAD, 1'b0, '0);
        idle(1);
        chk("R4", "dout held during swap", dout, pat(5));
        idle(1);
        chk("R4", "swap completed normally", dout, pat(2));
        goto(3'd5);
        chk("R4", "write during swap left context intact", dout, pat(5));

        // R8 request during busy dropped
        mtag = "R8";
        cyc(1'b0, '0, 1'b1, 3'd1);
        cyc(1'b0, '0, 1'b1, 3'd6);
        idle(2);
        chk("R8", "first swap target", active_idx, 1);
        chk("R8", "not busy after swap", busy, 0);
        idle(2);
        chk("R8", "dropped request not queued", active_idx, 1);
        chk("R8", "still not busy", busy, 0);

        // R7 same-index request
        mtag = "R7";
        cyc(1'b0, '0, 1'b1, 3'd1);
        idle(1);
        chk("R7", "no busy on same index", busy, 0);
        chk("R7", "index unchanged", active_idx, 1);
        chk("R7", "dout unchanged", dout, pat(1));
        cyc(1'b1, 16'h5A5A, 1'b1, 3'd1);
        idle(1);
        chk("R7", "write with same-index request", dout, 16'h5A5A);
        chk("R7", "busy stays low", busy, 0);

        // R9 write and accepted swap in same cycle
        mtag = "R9";
        cyc(1'b1, 16'hC3C3, 1'b1, 3'd4);
        idle(1);
        chk("R9", "swap accepted alongside write", busy, 1);
        idle(2);
        chk("R9", "arrived at target", dout, pat(4));
        goto(3'd1);
        chk("R9", "same-cycle write was parked", dout, 16'hC3C3);

        idle(2);
        finish_run();
    end

endmodule